// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block takes a single-precision result that still carries two bits of precision below its last significand bit and rounds it to the stored 32-bit word. The inputs are a sign, a biased 8-bit exponent, a 24-bit significand with the leading hidden one present, the two surplus low-order bits, and a 2-bit direction select. The output is the packed word with sign in bit 31, exponent in bits 30:23 and the 23-bit fraction in bits 22:0, where the hidden one is dropped. Two flags come with it: one marks a result that lost precision and one marks a result that ran past the largest finite exponent.

The block sits at the tail of an arithmetic pipeline. Its datapath is combinational. A parameter places an output register after the datapath, and that register is present by default, giving one cycle of latency. If the increment carries out of the significand, the block shifts right by one and raises the exponent by one. Exponent 255 and zero-exponent inputs are left to the stages around it.

Top module: `fp_round_unit`

## Requirements
- R1: While reset is held low, the word and both flags read zero. With the output register enabled, the outputs show the result for the inputs sampled at the previous rising clock edge.
- R2: Mode 2'b00 rounds to nearest. Surplus bits 2'b11 round the magnitude up and 2'b01 leave it unchanged. On the tie 2'b10, the magnitude goes up only when the significand LSB is 1, so the result always ends with an even LSB.
- R3: Mode 2'b01 rounds toward zero. It drops the surplus bits and never changes the magnitude.
- R4: Mode 2'b10 rounds toward plus infinity. A positive value with nonzero surplus bits gains one LSB of magnitude, and a negative value is truncated.
- R5: Mode 2'b11 rounds toward minus infinity. A negative value with nonzero surplus bits gains one LSB of magnitude, and a positive value is truncated.
- R6: When the surplus bits are 2'b00, every mode returns the input exponent and fraction unchanged.
- R7: The inexact flag is 1 exactly when the surplus bits are nonzero.
- R8: When the increment carries out of a significand of all ones, the fraction becomes zero and the exponent rises by one.
- R9: When that carry starts from exponent 254, the word becomes signed infinity (exponent 255, fraction 0) and the overflow flag is 1. In every other case the overflow flag is 0.
- R10: The sign bit of the word always equals the input sign, and the fraction field is the low 23 bits of the rounded significand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | 8 | Biased exponent |
| in_sig | input | 24 | Significand including the hidden one |
| in_ext | input | 2 | Surplus bits: bit 1 is worth half an LSB, bit 0 a quarter |
| in_mode | input | 2 | Direction select: 00 nearest even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_word | output | 32 | Rounded single-precision word |
| out_inexact | output | 1 | Result lost precision |
| out_overflow | output | 1 | Rounding produced infinity |

## Verification
The hardest case to reach is overflow. It needs three things at once: a significand of all ones, exponent 254, and a surplus pattern that actually increments under the selected mode. For the directed modes that also means the sign must match the direction. Random stimulus almost never lines these up, so the bench drives them as directed vectors. It also covers the near-miss cases: the same significand truncated, and the same vector with the sign that forbids the increment. Random vectors then sweep all modes over a restricted significand range. That range often hits the all-ones carry and the tie pattern.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

endpackage

// File: rtl/fpr_decide.sv
// Chooses whether the kept significand must gain one LSB.
module fpr_decide #(
    parameter int EXT_W = 2
) (
    input  logic             sign,
    input  logic             lsb,
    input  logic [EXT_W-1:0] ext,
    input  fpr_pkg::rmode_e  mode,
    output logic             inc,
    output logic             inexact
);
    import fpr_pkg::*;

    logic half_bit;
    logic sticky_bit;

    assign half_bit = ext[EXT_W-1];

    generate
        if (EXT_W > 1) begin : g_sticky
            assign sticky_bit = |ext[EXT_W-2:0];
        end else begin : g_nosticky
            assign sticky_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        inexact = half_bit | sticky_bit;
        unique case (mode)
            RM_NEAR: inc = half_bit & (sticky_bit | lsb);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = inexact & ~sign;
            RM_DOWN: inc = inexact & sign;
            default: inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpr_incr.sv
// Adds the rounding increment and renormalizes on carry-out.
module fpr_incr #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             inc,
    output logic [SIG_W-1:0] sig_out,
    output logic [EXP_W-1:0] exp_out,
    output logic             carry
);
    logic [SIG_W:0] sum;

    always_comb begin
        sum   = {1'b0, sig_in} + {{SIG_W{1'b0}}, inc};
        carry = sum[SIG_W];
        if (carry) begin
            sig_out = sum[SIG_W:1];
            exp_out = exp_in + {{(EXP_W-1){1'b0}}, 1'b1};
        end else begin
            sig_out = sum[SIG_W-1:0];
            exp_out = exp_in;
        end
    end
endmodule

// File: rtl/fpr_pack.sv
// Forms the stored word and replaces out-of-range results with infinity.
module fpr_pack #(
    parameter int SIG_W = 24,
    parameter int EXP_W = 8,
    localparam int FRAC_W = SIG_W - 1,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_r,
    input  logic [SIG_W-1:0]  sig_r,
    input  logic              carry,
    output logic [WORD_W-1:0] word,
    output logic              ovf
);
    localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

    always_comb begin
        ovf = carry && (exp_r == EXP_MAX);
        if (ovf) begin
            word = {sign, EXP_MAX, {FRAC_W{1'b0}}};
        end else begin
            word = {sign, exp_r, sig_r[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
    parameter int SIG_W   = 24,
    parameter int EXP_W   = 8,
    parameter int EXT_W   = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int FRAC_W = SIG_W - 1,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [SIG_W-1:0]  in_sig,
    input  logic [EXT_W-1:0]  in_ext,
    input  logic [1:0]        in_mode,
    output logic [WORD_W-1:0] out_word,
    output logic              out_inexact,
    output logic              out_overflow
);
    import fpr_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              inexact;
        logic              ovf;
    } res_t;

    rmode_e            mode_w;
    logic              inc_w;
    logic              inexact_w;
    logic [SIG_W-1:0]  sig_r_w;
    logic [EXP_W-1:0]  exp_r_w;
    logic              carry_w;
    logic [WORD_W-1:0] word_w;
    logic              ovf_w;
    res_t              res_d;
    res_t              res_q;

    assign mode_w = rmode_e'(in_mode);

    fpr_decide #(.EXT_W(EXT_W)) u_decide (
        .sign    (in_sign),
        .lsb     (in_sig[0]),
        .ext     (in_ext),
        .mode    (mode_w),
        .inc     (inc_w),
        .inexact (inexact_w)
    );

    fpr_incr #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_incr (
        .sig_in  (in_sig),
        .exp_in  (in_exp),
        .inc     (inc_w),
        .sig_out (sig_r_w),
        .exp_out (exp_r_w),
        .carry   (carry_w)
    );

    fpr_pack #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_pack (
        .sign  (in_sign),
        .exp_r (exp_r_w),
        .sig_r (sig_r_w),
        .carry (carry_w),
        .word  (word_w),
        .ovf   (ovf_w)
    );

    always_comb begin
        res_d         = '0;
        res_d.word    = word_w;
        res_d.inexact = inexact_w;
        res_d.ovf     = ovf_w;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            assign res_q = rst_n ? res_d : '0;
        end
    endgenerate

    assign out_word     = res_q.word;
    assign out_inexact  = res_q.inexact;
    assign out_overflow = res_q.ovf;

    // R3: toward-zero never adds an LSB
    assert_trunc_no_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == RM_ZERO) |-> !inc_w);

    // R4: toward +inf leaves negative magnitudes alone
    assert_up_neg_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == RM_UP && in_sign) |-> !inc_w);

    // R5: toward -inf leaves positive magnitudes alone
    assert_down_pos_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == RM_DOWN && !in_sign) |-> !inc_w);

    // R2: a tie with an even LSB stays put
    assert_tie_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == RM_NEAR && in_ext == {1'b1, {(EXT_W-1){1'b0}}} && !in_sig[0]) |-> !inc_w);

    // R7: an increment only happens on an inexact value
    assert_inc_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inc_w |-> inexact_w);

    // R8: renormalized result has a clean fraction and a raised exponent
    assert_renorm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_w |-> (sig_r_w[FRAC_W-1:0] == '0 && exp_r_w == in_exp + 1'b1));

    // R8: without carry the exponent is untouched
    assert_exp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_w |-> (exp_r_w == in_exp));

    // R9: overflow produces signed infinity
    assert_ovf_inf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_d.ovf |-> (res_d.word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                       && res_d.word[WORD_W-1] == in_sign));

    // R1: registered outputs follow the previous cycle's result
    generate
        if (REG_OUT) begin : g_lat_chk
            assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (res_q == $past(res_d)));
        end
    endgenerate
endmodule

// File: tb/tb_fp_round_unit.sv
module tb_fp_round_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_sign = 1'b0;
    logic [7:0]  in_exp = '0;
    logic [23:0] in_sig = '0;
    logic [1:0]  in_ext = '0;
    logic [1:0]  in_mode = '0;
    logic [31:0] out_word;
    logic        out_inexact;
    logic        out_overflow;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] exp_word;
    bit          exp_inx;
    bit          exp_ovf;
    string       exp_tag;
    bit          pend = 0;

    always #10 clk = ~clk;

    fp_round_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_sign      (in_sign),
        .in_exp       (in_exp),
        .in_sig       (in_sig),
        .in_ext       (in_ext),
        .in_mode      (in_mode),
        .out_word     (out_word),
        .out_inexact  (out_inexact),
        .out_overflow (out_overflow)
    );

    // Behavioural reference: integer rounding on value = sig + ext/4
    task automatic model(input bit s, input int e, input int sig, input int ext,
                         input int md, output logic [31:0] w, output bit inx,
                         output bit ov, output string tag);
        int q;
        bit up;
        q = sig;
        case (md)
            0: up = (ext > 2) || (ext == 2 && (q % 2) == 1);
            1: up = 0;
            2: up = (ext != 0) && !s;
            default: up = (ext != 0) && s;
        endcase
        q = q + (up ? 1 : 0);
        tag = (md == 0) ? "R2" : (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
        if (ext == 0) tag = "R6";
        if (q == (1 << 24)) begin
            q = 1 << 23;
            e = e + 1;
            tag = "R8";
        end
        inx = (ext != 0);
        ov  = (e >= 255);
        if (ov) begin
            w = {s, 8'hFF, 23'd0};
            tag = "R9";
        end else begin
            w = {s, e[7:0], q[22:0]};
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            chk(out_word == exp_word, exp_tag, out_word, exp_word);
            chk(out_word[31] == exp_word[31], "R10", {31'd0, out_word[31]}, {31'd0, exp_word[31]});
            chk(out_inexact == exp_inx, "R7", {31'd0, out_inexact}, {31'd0, exp_inx});
            chk(out_overflow == exp_ovf, "R9", {31'd0, out_overflow}, {31'd0, exp_ovf});
        end
    endtask

    task automatic apply(input bit s, input int e, input int sig, input int ext, input int md);
        @(negedge clk);
        check_pending();
        in_sign = s;
        in_exp  = e[7:0];
        in_sig  = sig[23:0];
        in_ext  = ext[1:0];
        in_mode = md[1:0];
        model(s, e, sig, ext, md, exp_word, exp_inx, exp_ovf, exp_tag);
        pend = 1;
    endtask

    initial begin
        // R1: outputs held at zero under reset even with live inputs
        in_sign = 1'b1; in_exp = 8'd200; in_sig = 24'hFFFFFF; in_ext = 2'b11;
        repeat (3) @(negedge clk);
        chk(out_word == 32'd0 && !out_inexact && !out_overflow, "R1",
            out_word, 32'd0);
        rst_n = 1'b1;

        // R2 nearest even
        apply(0, 127, 24'h800000, 3, 0);
        apply(0, 127, 24'h800000, 1, 0);
        apply(0, 127, 24'h800000, 2, 0);
        apply(1, 127, 24'h800001, 2, 0);
        apply(0, 130, 24'hABCDEF, 2, 0);
        // R3 toward zero
        apply(0, 127, 24'h800001, 3, 1);
        apply(1, 127, 24'hFFFFFF, 3, 1);
        // R4 toward +inf
        apply(0, 127, 24'h800000, 1, 2);
        apply(1, 127, 24'h800000, 3, 2);
        // R5 toward -inf
        apply(1, 127, 24'h800000, 1, 3);
        apply(0, 127, 24'h800000, 3, 3);
        // R6 exact in every mode
        for (int m = 0; m < 4; m++) apply(m[0], 90, 24'hC0FFEE, 0, m);
        // R8 carry-out renormalizes
        apply(0, 100, 24'hFFFFFF, 3, 0);
        apply(1, 1, 24'hFFFFFF, 1, 3);
        // R9 overflow into infinity, and near misses
        apply(0, 254, 24'hFFFFFF, 1, 2);
        apply(1, 254, 24'hFFFFFF, 3, 3);
        apply(0, 254, 24'hFFFFFF, 3, 0);
        apply(0, 254, 24'hFFFFFF, 3, 1);
        apply(1, 254, 24'hFFFFFF, 3, 2);
        apply(0, 254, 24'hFFFFFE, 2, 0);
        // random sweep with a biased significand tail
        for (int i = 0; i < 400; i++) begin
            int e;
            int sg;
            e  = 1 + int'($urandom_range(253));
            sg = int'({1'b1, $urandom_range(1) ? 23'h7FFFFF : 23'(($urandom() & 32'h7FFFFF) | 32'h7FFFF0)});
            if ($urandom_range(3) == 0) sg = int'({1'b1, 23'($urandom())});
            apply(1'($urandom_range(1)), e, sg, int'($urandom_range(3)), int'($urandom_range(3)));
        end
        @(negedge clk);
        check_pending();
        pend = 0;

        // R1: reasserting reset clears the outputs
        rst_n = 1'b0;
        in_ext = 2'b11;
        @(negedge clk);
        chk(out_word == 32'd0 && !out_inexact && !out_overflow, "R1", out_word, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule